// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

A memory-mapped interrupt controller that collects up to `NUM_BANKS*32` level-sensitive sources, grouped into banks of 32, and presents one interrupt request line to a processor. Software reaches it through a simple 32-bit word-access register port. Each bank has its own mask and software-trigger state. Each kind of state has a write-one-to-set address and a write-one-to-clear address, spaced at a fixed 0x20 stride per bank, so that software never needs a read-modify-write.

A source is pending when its input line or its software-trigger bit is high and its mask bit is low. When nothing is latched, the lowest-numbered pending source is captured into an active-number register and the request line goes high. That number is frozen until software writes the acknowledge bit in the control register. The controller then drops the request for one cycle, re-evaluates and latches the next winner. The block also provides a timed soft reset with a completion flag, a read-only revision word and an 8-bit priority threshold.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After `rst_ni` is released, every mask register reads 0xFFFFFFFF, every software-trigger register reads 0, the active-number register at 0x40 reads 0x00000080, the status register at 0x14 reads 1, the threshold register at 0x68 reads 0xFF and `irq_o` is 0.
- R2: For bank n, writing to 0x88+n*0x20 clears the mask bits written as 1, and writing to 0x8C+n*0x20 sets them. Zero bits leave the mask unchanged. Reading either address returns the bank's mask, and source s maps to bank s>>5, bit s&31.
- R3: For bank n, writing to 0x90+n*0x20 sets the software-trigger bits written as 1, and writing to 0x94+n*0x20 clears them. Zero bits have no effect. Reading either address returns the bank's trigger bits.
- R4: A source is pending only when (input OR software-trigger) AND NOT mask is true for it. A masked source is never latched.
- R5: When several sources are pending, the lowest source number is latched. A read of 0x40 while a number is latched returns that number in bits [6:0] with all higher bits 0.
- R6: Once a number is latched it does not change, and `irq_o` stays 1, until an acknowledge, even if a lower-numbered source becomes pending or the latched source goes low.
- R7: Writing bit 0 = 1 to the control register at 0x48 acknowledges. In the next cycle `irq_o` is 0 and 0x40 reads 0x80. In the cycle after that, the next winner, if any, is latched. Writing 0 to 0x48 has no effect.
- R8: While no number is latched, a read of 0x40 returns 0x00000080 (bit 7 flags that no valid interrupt is held).
- R9: Writing bit 1 = 1 to 0x10 starts a soft reset. The latched number is dropped at once. For `RST_CYCLES` cycles, 0x14 bit 0 reads 0, 0x10 bit 1 reads 1 and register writes are ignored. Afterwards all state holds its R1 values, 0x14 reads 1 and 0x10 reads 0.
- R10: The register at 0x00 reads `REV_MAJOR` in bits [7:4] and `REV_MINOR` in bits [3:0], with all other bits 0.
- R11: The threshold at 0x68 is 8 bits wide and readable. Every source has the fixed priority 0. A new number is latched only when the threshold is 0xFF or is greater than 0, so a threshold of 0 holds off latching. A number that is already latched is not affected.
- R12: `irq_o` is 1 exactly while a number is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt source lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when no read is requested |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with its defaults: four banks, a four-cycle soft reset and revision 5.0. With four banks, the top source 127 and a cross-bank race between sources 64 and 127 are both reachable, so the bench can check the full seven-bit number field and lowest-number priority across bank boundaries. The short reset window lets the bench sample the status bit on the last busy cycle and on the first idle cycle. It also confirms that a mask write landing inside the window is discarded.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_REV     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_SYSSTAT = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_ACTIVE  = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_THRESH  = 12'h068;
  localparam logic [ADDR_W-1:0] OFF_BANK0   = 12'h088;
  localparam int unsigned       BANK_STRIDE = 32;

  localparam logic [WORD_W-1:0] NO_IRQ_WORD = 32'h0000_0080;
  localparam logic [7:0]        THR_OFF     = 8'hFF;
  localparam logic [7:0]        SRC_PRIO    = 8'h00;

  typedef enum logic [1:0] {
    BR_MSK_CLR = 2'd0,
    BR_MSK_SET = 2'd1,
    BR_SWI_SET = 2'd2,
    BR_SWI_CLR = 2'd3
  } bank_reg_e;

  function automatic logic [ADDR_W-1:0] bank_addr(input int unsigned bank, input bank_reg_e r);
    return ADDR_W'(int'(OFF_BANK0) + int'(bank) * int'(BANK_STRIDE) + int'(r) * 4);
  endfunction
endpackage

// File: rtl/birq_bank.sv
module birq_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         msk_clr_i,
  input  logic         msk_set_i,
  input  logic         swi_set_i,
  input  logic         swi_clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] swi_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] mask_q, swi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (clr_i) begin
      mask_q <= '1;
    end else if (msk_clr_i) begin
      mask_q <= mask_q & ~wdata_i;
    end else if (msk_set_i) begin
      mask_q <= mask_q | wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swi_q <= '0;
    end else if (clr_i) begin
      swi_q <= '0;
    end else if (swi_set_i) begin
      swi_q <= swi_q | wdata_i;
    end else if (swi_clr_i) begin
      swi_q <= swi_q & ~wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign swi_o  = swi_q;
  assign pend_o = (src_i | swi_q) & ~mask_q;
endmodule

// File: rtl/birq_prio.sv
module birq_prio #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // descending scan: the last hit, i.e. the lowest index, wins
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/birq_srst.sv
module birq_srst #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import birq_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned RST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR  = 4'd5,
  parameter logic [3:0]  REV_MINOR  = 4'd0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*WORD_W-1:0] src_i,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  output logic                        irq_o
);
  localparam int unsigned NSRC  = NUM_BANKS * WORD_W;
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic                            srst_busy, srst_start, soft_clr;
  logic                            wr_ok, ack;
  logic [NUM_BANKS-1:0][WORD_W-1:0] mask, swi;
  logic [NSRC-1:0]                 pend;
  logic                            found;
  logic [IDX_W-1:0]                win;
  logic                            held_v_q;
  logic [IDX_W-1:0]                held_num_q;
  logic [7:0]                      thresh_q;
  logic                            thr_pass;

  assign wr_ok      = req_i & we_i & ~srst_busy;
  assign srst_start = wr_ok && (addr_i == OFF_SYSCFG) && wdata_i[1];
  assign ack        = wr_ok && (addr_i == OFF_CTRL) && wdata_i[0];
  assign soft_clr   = srst_start | srst_busy;

  birq_srst #(.CYCLES(RST_CYCLES)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .busy_o  (srst_busy)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic en_mc, en_ms, en_ss, en_sc;
    assign en_mc = wr_ok && (addr_i == bank_addr(b, BR_MSK_CLR));
    assign en_ms = wr_ok && (addr_i == bank_addr(b, BR_MSK_SET));
    assign en_ss = wr_ok && (addr_i == bank_addr(b, BR_SWI_SET));
    assign en_sc = wr_ok && (addr_i == bank_addr(b, BR_SWI_CLR));

    birq_bank #(.W(WORD_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (soft_clr),
      .msk_clr_i (en_mc),
      .msk_set_i (en_ms),
      .swi_set_i (en_ss),
      .swi_clr_i (en_sc),
      .wdata_i   (wdata_i),
      .src_i     (src_i[b*WORD_W +: WORD_W]),
      .mask_o    (mask[b]),
      .swi_o     (swi[b]),
      .pend_o    (pend[b*WORD_W +: WORD_W])
    );
  end

  birq_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
    .req_i   (pend),
    .found_o (found),
    .idx_o   (win)
  );

  assign thr_pass = (thresh_q == THR_OFF) || (SRC_PRIO < thresh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q <= THR_OFF;
    end else if (soft_clr) begin
      thresh_q <= THR_OFF;
    end else if (wr_ok && (addr_i == OFF_THRESH)) begin
      thresh_q <= wdata_i[7:0];
    end
  end

  // latched number frozen until acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_v_q   <= 1'b0;
      held_num_q <= '0;
    end else if (soft_clr || ack) begin
      held_v_q   <= 1'b0;
    end else if (!held_v_q && found && thr_pass) begin
      held_v_q   <= 1'b1;
      held_num_q <= win;
    end
  end

  assign irq_o = held_v_q;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        OFF_REV:     rdata_o = {{(WORD_W-8){1'b0}}, REV_MAJOR, REV_MINOR};
        OFF_SYSCFG:  rdata_o = {{(WORD_W-2){1'b0}}, srst_busy, 1'b0};
        OFF_SYSSTAT: rdata_o = {{(WORD_W-1){1'b0}}, ~srst_busy};
        OFF_ACTIVE:  rdata_o = held_v_q ? {{(WORD_W-IDX_W){1'b0}}, held_num_q} : NO_IRQ_WORD;
        OFF_THRESH:  rdata_o = {{(WORD_W-8){1'b0}}, thresh_q};
        default: begin
          for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (addr_i == bank_addr(b, BR_MSK_CLR) || addr_i == bank_addr(b, BR_MSK_SET))
              rdata_o = mask[b];
            if (addr_i == bank_addr(b, BR_SWI_SET) || addr_i == bank_addr(b, BR_SWI_CLR))
              rdata_o = swi[b];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
module bank_irq_ctrl_chk
  import birq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned IDX_W     = 7
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        ack_bit_i,
  input logic                        srst_bit_i,
  input logic [WORD_W-1:0]           rdata_i,
  input logic                        irq_o,
  input logic [IDX_W-1:0]            held_num_i,
  input logic                        busy_i,
  input logic [NUM_BANKS*WORD_W-1:0] pend_i
);
  localparam int unsigned NSRC = NUM_BANKS * WORD_W;

  logic rd_active, ack_wr, srst_wr;
  assign rd_active = req_i && !we_i && (addr_i == OFF_ACTIVE);
  assign ack_wr    = req_i && we_i && (addr_i == OFF_CTRL) && ack_bit_i;
  assign srst_wr   = req_i && we_i && (addr_i == OFF_SYSCFG) && srst_bit_i;

  AST_IDLE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active |-> (rdata_i[7] == !irq_o)); // R8

  AST_ACTIVE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active && irq_o) |-> (rdata_i[WORD_W-1:IDX_W] == '0 && rdata_i[IDX_W-1:0] == held_num_i)); // R5

  AST_LATCH_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((($past(pend_i) >> held_num_i) & NSRC'(1)) != '0)); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (($past(pend_i) & ((NSRC'(1) << held_num_i) - NSRC'(1))) == '0)); // R5

  AST_HOLD_NUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_wr && !busy_i && !srst_wr) |=> (irq_o && $stable(held_num_i))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !busy_i) |=> !irq_o); // R7

  AST_SRST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_wr && !busy_i) |=> (busy_i && !irq_o)); // R9

  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !irq_o); // R9
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .ack_bit_i  (wdata_i[0]),
  .srst_bit_i (wdata_i[1]),
  .rdata_i    (rdata_o),
  .irq_o      (irq_o),
  .held_num_i (held_num_q),
  .busy_i     (srst_busy),
  .pend_i     (pend)
);

// File: tb/bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module bank_irq_ctrl_tb;
  import birq_pkg::*;

  localparam int unsigned NB   = 4;
  localparam int unsigned NSRC = NB * WORD_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   src = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic              irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [WORD_W-1:0] exp;
    string             tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t item;

  always #2 clk = ~clk;

  bank_irq_ctrl #(.NUM_BANKS(NB), .RST_CYCLES(4), .REV_MAJOR(4'd5), .REV_MINOR(4'd0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && req && !we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        item = exp_q.pop_front();
        if (rdata !== item.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", item.tag, rdata, item.exp);
        end
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] e, input string t);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back('{exp: e, tag: t});
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    for (int b = 0; b < int'(NB); b++) rd(bank_addr(b, BR_MSK_CLR), 32'hFFFF_FFFF, "R1 mask reset");
    rd(bank_addr(0, BR_SWI_SET), 32'h0, "R1 swi reset");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R1 R8 active idle");
    rd(OFF_SYSSTAT, 32'h1, "R1 status done");
    rd(OFF_THRESH, 32'hFF, "R1 R11 threshold reset");
    chk_irq(1'b0, "R1 R12 irq reset");
    rd(OFF_REV, 32'h50, "R10 revision");

    // mask set/clear
    wr(bank_addr(1, BR_MSK_CLR), 32'h5);
    rd(bank_addr(1, BR_MSK_CLR), 32'hFFFF_FFFA, "R2 mask clear");
    wr(bank_addr(1, BR_MSK_SET), 32'h1);
    rd(bank_addr(1, BR_MSK_SET), 32'hFFFF_FFFB, "R2 mask set");
    wr(bank_addr(1, BR_MSK_CLR), 32'h0);
    rd(bank_addr(1, BR_MSK_CLR), 32'hFFFF_FFFB, "R2 zero bits no effect");

    // masked source ignored, unmasked one latched
    src[40] = 1'b1;
    idle(1);
    chk_irq(1'b0, "R4 masked source");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R4 masked not latched");
    src[34] = 1'b1;
    idle(1);
    chk_irq(1'b1, "R12 irq on latch");
    rd(OFF_ACTIVE, 32'd34, "R4 unmasked latched");

    // hold against a lower source and a dropped line
    wr(bank_addr(0, BR_MSK_CLR), 32'h8);
    wr(bank_addr(0, BR_SWI_SET), 32'h8);
    idle(1);
    rd(OFF_ACTIVE, 32'd34, "R6 hold vs lower source");
    src[34] = 1'b0;
    idle(1);
    chk_irq(1'b1, "R6 irq held after drop");
    rd(OFF_ACTIVE, 32'd34, "R6 hold after drop");
    rd(bank_addr(0, BR_SWI_SET), 32'h8, "R3 swi set");
    rd(bank_addr(0, BR_SWI_CLR), 32'h8, "R3 swi read alias");

    // acknowledge
    wr(OFF_CTRL, 32'h0);
    rd(OFF_ACTIVE, 32'd34, "R7 zero write no ack");
    wr(OFF_CTRL, 32'h1);
    chk_irq(1'b0, "R7 irq drops after ack");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R7 R8 idle after ack");
    chk_irq(1'b1, "R7 relatch");
    rd(OFF_ACTIVE, 32'd3, "R7 next winner");

    // software clear
    wr(bank_addr(0, BR_SWI_CLR), 32'h8);
    rd(bank_addr(0, BR_SWI_SET), 32'h0, "R3 swi clear");
    rd(OFF_ACTIVE, 32'd3, "R6 hold after swi clear");
    wr(OFF_CTRL, 32'h1);
    idle(2);
    chk_irq(1'b0, "R12 nothing pending");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R8 nothing pending");

    // cross-bank priority and top source
    wr(bank_addr(3, BR_MSK_CLR), 32'h8000_0000);
    wr(bank_addr(2, BR_MSK_CLR), 32'h1);
    src[127] = 1'b1;
    src[64]  = 1'b1;
    idle(1);
    rd(OFF_ACTIVE, 32'd64, "R5 lowest across banks");
    src[64] = 1'b0;
    wr(OFF_CTRL, 32'h1);
    idle(1);
    rd(OFF_ACTIVE, 32'h7F, "R5 top source field");

    // threshold
    wr(OFF_THRESH, 32'h0);
    rd(OFF_THRESH, 32'h0, "R11 threshold readback");
    rd(OFF_ACTIVE, 32'h7F, "R11 latched unaffected");
    wr(OFF_CTRL, 32'h1);
    idle(2);
    chk_irq(1'b0, "R11 threshold 0 blocks");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R11 blocked idle");
    wr(OFF_THRESH, 32'h10);
    idle(1);
    chk_irq(1'b1, "R11 threshold above prio passes");
    rd(OFF_ACTIVE, 32'h7F, "R11 latched after pass");
    rd(OFF_THRESH, 32'h10, "R11 threshold value");

    // soft reset
    wr(OFF_SYSCFG, 32'h2);
    chk_irq(1'b0, "R9 irq dropped at start");
    rd(OFF_SYSSTAT, 32'h0, "R9 busy cycle 1");
    wr(bank_addr(0, BR_MSK_CLR), 32'hFFFF_FFFF);
    rd(OFF_SYSCFG, 32'h2, "R9 request bit while busy");
    rd(OFF_SYSSTAT, 32'h0, "R9 busy last cycle");
    rd(OFF_SYSSTAT, 32'h1, "R9 done");
    rd(OFF_SYSCFG, 32'h0, "R9 request self-clears");
    rd(bank_addr(0, BR_MSK_CLR), 32'hFFFF_FFFF, "R9 write ignored and mask reset");
    rd(bank_addr(3, BR_MSK_SET), 32'hFFFF_FFFF, "R9 mask reset bank3");
    rd(OFF_THRESH, 32'hFF, "R9 threshold reset");
    chk_irq(1'b0, "R9 R12 irq after soft reset");
    rd(OFF_ACTIVE, NO_IRQ_WORD, "R9 active idle");

    idle(2);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule